// File: doc/BRIEF.md
# Indirect-Addressed I/O Register Window

This block is a slave on a PC-style I/O bus. It answers a 24-byte window that starts at a base address supplied on an input. The low 16 bytes of the window return a fixed station address and cannot be written. Above that area sit four 16-bit locations: a pointer, two data ports and a soft reset port. The two data ports reach two separate register banks, and one pointer register selects the entry in both. Software writes the pointer first and then reads or writes either data port.

The host can run the window in 16-bit mode, where each strobe moves one whole word, or in byte mode. In byte mode a 16-bit software access reaches the block as two byte cycles, the low byte first and then the high byte. Data always travels on the low lane in byte mode. A write commits only when its second half arrives. A read captures the full word on its first half, so the two halves always come from the same value. A read of the reset port starts an internal reset pulse of fixed length. The pulse clears the pointer and both banks.

Top module: `isa_io_window`

## Requirements
- R1: `sel` is high only while a strobe is active and `addr - base_addr` lies in 0x00..0x17 with `addr >= base_addr`. Outside that window `sel` is low and `rdata` is 0.
- R2: In 16-bit mode, offsets 0x00..0x0F return the station bytes. Byte i is `STATION[8i+7:8i]` and the word at even offset 2k is {byte 2k+1, byte 2k}. Writes to these offsets change nothing.
- R3: The pointer sits at offset 0x12. It reads back with its RAP_W (default 4) low bits and zeros above, and a port reset sets it to 0.
- R4: Offset 0x10 reads and writes entry [pointer] of bank A. Offset 0x16 reads and writes entry [pointer] of bank B, which is a separate bank. Each bank has 2**RAP_W 16-bit entries.
- R5: A read of offset 0x14 or 0x15, in either mode, drives `soft_rst` high from the next clock for exactly RST_CYC cycles (default 4). A write there leaves `soft_rst` low.
- R6: While `soft_rst` is high, the pointer and every entry of both banks are cleared to 0.
- R7: In byte mode, a write to an even offset only stages the low byte. The register takes {high byte, staged low byte} when the next write goes to the odd offset of the same word.
- R8: In byte mode, a read of the even offset of a port (0x10..0x17) captures the whole register. A later read of the odd offset returns the captured upper byte, even if the register has changed since.
- R9: In byte mode, read data appears on `rdata[7:0]` with `rdata[15:8]` zero, and an odd station byte is steered to the low lane. Write data is taken from `wdata[7:0]`.
- R10: `cs16` is high only in 16-bit mode, for a selected access at offsets 0x10..0x17.
- R11: In 16-bit mode, address bit 0 is ignored and a whole word is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low port reset |
| base_addr | input | ADDR_W | Window base address |
| addr | input | ADDR_W | I/O address |
| ior | input | 1 | Read strobe, one cycle per access |
| iow | input | 1 | Write strobe, one cycle per access |
| byte_mode | input | 1 | 1 = byte cycles, 0 = 16-bit cycles |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, 0 when not selected |
| sel | output | 1 | Window select acknowledge |
| cs16 | output | 1 | 16-bit cycle select |
| soft_rst | output | 1 | Internal reset pulse |

## Verification
The assertions assume that `ior` and `iow` are never high together. They also assume that each strobe is one clock long and stands for exactly one access, and that `base_addr` and `byte_mode` hold still while a strobe is active. The bench drives every access through a single read task and a single write task. Each task raises one strobe for one cycle and changes address, data and mode only between accesses. The bench also waits for `soft_rst` to end before it issues the next access.

// File: rtl/isa_io_window.sv
module isa_io_window #(
  parameter int ADDR_W = 10,
  parameter int RAP_W = 4,
  parameter int RST_CYC = 4,
  parameter logic [127:0] STATION = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ior,
  input  logic              iow,
  input  logic              byte_mode,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              sel,
  output logic              cs16,
  output logic              soft_rst
);
  localparam int NREG = 1 << RAP_W;
  localparam int CW = $clog2(RST_CYC + 1);
  localparam int WIN = 24;

  logic [ADDR_W-1:0] diff;
  logic              hit;
  logic [4:0]        off;
  logic [3:0]        widx;
  logic              is_port;

  logic [RAP_W-1:0]  ptr;
  logic [15:0]       bank_a [NREG];
  logic [15:0]       bank_b [NREG];
  logic [CW-1:0]     rcnt;
  logic [7:0]        stage_lo;
  logic [3:0]        stage_idx;
  logic              stage_v;
  logic [7:0]        hold_hi;

  logic [15:0]       rd_word;
  logic              wr_go;
  logic [15:0]       wr_word;
  logic              rst_hit;

  assign diff    = addr - base_addr;
  assign hit     = (addr >= base_addr) && (diff < ADDR_W'(WIN));
  assign off     = diff[4:0];
  assign widx    = off[4:1];
  assign is_port = off[4];

  assign sel      = hit && (ior || iow);
  assign cs16     = sel && !byte_mode && is_port;
  assign soft_rst = (rcnt != '0);
  assign rst_hit  = ior && hit && (widx == 4'd10);

  always_comb begin
    rd_word = 16'h0000;
    if (!is_port)
      rd_word = STATION[{widx[2:0], 4'b0000} +: 16];
    else
      case (widx)
        4'd8:    rd_word = bank_a[ptr];
        4'd9:    rd_word = {{(16-RAP_W){1'b0}}, ptr};
        4'd11:   rd_word = bank_b[ptr];
        default: rd_word = 16'h0000;
      endcase
  end

  always_comb begin
    rdata = 16'h0000;
    if (ior && hit) begin
      if (!byte_mode)
        rdata = rd_word;
      else if (!off[0])
        rdata = {8'h00, rd_word[7:0]};
      else if (!is_port)
        rdata = {8'h00, rd_word[15:8]};
      else
        rdata = {8'h00, hold_hi};
    end
  end

  always_comb begin
    wr_go   = 1'b0;
    wr_word = wdata;
    if (iow && hit) begin
      if (!byte_mode)
        wr_go = 1'b1;
      else if (off[0] && stage_v && stage_idx == widx) begin
        wr_go   = 1'b1;
        wr_word = {wdata[7:0], stage_lo};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rcnt <= '0;
    else if (rst_hit && !soft_rst)
      rcnt <= CW'(RST_CYC);
    else if (soft_rst)
      rcnt <= rcnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_v   <= 1'b0;
      stage_lo  <= 8'h00;
      stage_idx <= 4'd0;
      hold_hi   <= 8'h00;
    end else begin
      if (iow && hit && byte_mode) begin
        if (!off[0]) begin
          stage_v   <= 1'b1;
          stage_lo  <= wdata[7:0];
          stage_idx <= widx;
        end else begin
          stage_v <= 1'b0;
        end
      end
      if (ior && hit && byte_mode && is_port && !off[0])
        hold_hi <= rd_word[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (soft_rst)
      ptr <= '0;
    else if (wr_go && widx == 4'd9)
      ptr <= wr_word[RAP_W-1:0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_a[g] <= 16'h0000;
        bank_b[g] <= 16'h0000;
      end else if (soft_rst) begin
        bank_a[g] <= 16'h0000;
        bank_b[g] <= 16'h0000;
      end else if (wr_go && ptr == RAP_W'(g)) begin
        if (widx == 4'd8)  bank_a[g] <= wr_word;
        if (widx == 4'd11) bank_b[g] <= wr_word;
      end
    end
  end
endmodule

module isa_io_window_chk #(
  parameter int ADDR_W = 10,
  parameter int RAP_W = 4,
  parameter int RST_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] addr,
  input logic              ior,
  input logic              iow,
  input logic              byte_mode,
  input logic [15:0]       rdata,
  input logic              sel,
  input logic              cs16,
  input logic              soft_rst,
  input logic [RAP_W-1:0]  ptr
);
  logic [ADDR_W-1:0] d;
  logic              inwin;
  logic              at_rst;
  int                run_len;

  assign d      = addr - base_addr;
  assign inwin  = (addr >= base_addr) && (d <= ADDR_W'(23));
  assign at_rst = inwin && (d[4:1] == 4'd10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (soft_rst) run_len <= run_len + 1;
    else run_len <= 0;
  end

  a_r1_no_sel_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !inwin |-> !sel);
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> rdata == 16'h0000);
  a_r9_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && byte_mode) |-> rdata[15:8] == 8'h00);
  a_r10_cs16_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cs16 |-> (sel && !byte_mode && d >= ADDR_W'(16)));
  a_r5_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (ior && at_rst && !soft_rst) |=> soft_rst);
  a_r5_write_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (iow && at_rst && !soft_rst) |=> !soft_rst);
  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RST_CYC);
  a_r6_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ptr == '0);
endmodule

bind isa_io_window isa_io_window_chk #(
  .ADDR_W(ADDR_W), .RAP_W(RAP_W), .RST_CYC(RST_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .base_addr(base_addr), .addr(addr),
  .ior(ior), .iow(iow), .byte_mode(byte_mode), .rdata(rdata),
  .sel(sel), .cs16(cs16), .soft_rst(soft_rst), .ptr(ptr)
);

// File: tb/sim_isa_io_window.sv
module sim_isa_io_window;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  base_addr = 10'h300;
  logic [9:0]  addr = 0;
  logic        ior = 0, iow = 0, byte_mode = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        sel, cs16, soft_rst;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] r_d;
  logic r_sel, r_cs;

  always #10 clk = ~clk;

  isa_io_window u0 (.clk(clk), .rst_n(rst_n), .base_addr(base_addr), .addr(addr),
    .ior(ior), .iow(iow), .byte_mode(byte_mode), .wdata(wdata), .rdata(rdata),
    .sel(sel), .cs16(cs16), .soft_rst(soft_rst));

  function automatic logic [7:0] st_byte(int i);
    return 8'((i << 4) | (15 - i));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_rd(logic [9:0] a);
    @(negedge clk); addr = a; ior = 1;
    #5; r_d = rdata; r_sel = sel; r_cs = cs16;
    @(negedge clk); ior = 0;
  endtask

  task automatic io_wr(logic [9:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; iow = 1;
    @(negedge clk); iow = 0;
  endtask

  task automatic t_reset;
    check("R3 reset soft_rst", soft_rst, 0);
    check("R1 idle sel", sel, 0);
    io_rd(10'h312); check("R3 ptr after reset", r_d, 0);
  endtask

  task automatic t_decode;
    io_rd(10'h318); check("R1 above window sel", r_sel, 0); check("R1 above rdata", r_d, 0);
    io_rd(10'h2FF); check("R1 below window sel", r_sel, 0);
    io_rd(10'h317); check("R1 top offset sel", r_sel, 1);
  endtask

  task automatic t_station;
    for (int k = 0; k < 8; k++) begin
      io_rd(10'h300 + 10'(2*k));
      check("R2 station word", r_d, {st_byte(2*k+1), st_byte(2*k)});
    end
    io_rd(10'h305); check("R11 odd addr ignored", r_d, {st_byte(5), st_byte(4)});
    io_wr(10'h304, 16'h0000);
    io_rd(10'h304); check("R2 write ignored", r_d, {st_byte(5), st_byte(4)});
  endtask

  task automatic t_banks;
    io_wr(10'h312, 16'h0003);
    io_wr(10'h310, 16'h1234);
    io_wr(10'h316, 16'hABCD);
    io_wr(10'h312, 16'h0005);
    io_wr(10'h310, 16'h5555);
    io_rd(10'h310); check("R4 bank A entry 5", r_d, 16'h5555);
    io_rd(10'h316); check("R4 bank B entry 5", r_d, 0);
    io_wr(10'h312, 16'hFFF3);
    io_rd(10'h312); check("R3 ptr width", r_d, 16'h0003);
    io_rd(10'h310); check("R4 bank A entry 3", r_d, 16'h1234);
    io_rd(10'h316); check("R4 bank B entry 3", r_d, 16'hABCD);
  endtask

  task automatic t_cs16;
    io_rd(10'h310); check("R10 cs16 port", r_cs, 1);
    io_rd(10'h300); check("R10 cs16 station", r_cs, 0);
    byte_mode = 1;
    io_rd(10'h312); check("R10 cs16 byte mode", r_cs, 0);
    byte_mode = 0;
  endtask

  task automatic t_byte_write;
    byte_mode = 1;
    io_wr(10'h312, 16'hFF07);
    byte_mode = 0; io_rd(10'h312); check("R7 ptr staged only", r_d, 16'h0003);
    byte_mode = 1; io_wr(10'h313, 16'hFF00);
    byte_mode = 0; io_rd(10'h312); check("R7 ptr committed", r_d, 16'h0007);
    byte_mode = 1; io_wr(10'h310, 16'h55CD);
    byte_mode = 0; io_rd(10'h310); check("R7 reg staged only", r_d, 0);
    byte_mode = 1; io_wr(10'h311, 16'h77EF);
    byte_mode = 0; io_rd(10'h310); check("R9 R7 reg committed", r_d, 16'hEFCD);
  endtask

  task automatic t_coherent;
    byte_mode = 1;
    io_rd(10'h310); check("R9 low byte lane", r_d, 16'h00CD);
    io_wr(10'h310, 16'h0011);
    io_wr(10'h311, 16'h0022);
    io_rd(10'h311); check("R8 captured high", r_d, 16'h00EF);
    io_rd(10'h309); check("R9 odd station steer", r_d, {8'h00, st_byte(9)});
    byte_mode = 0;
    io_rd(10'h310); check("R8 new value", r_d, 16'h2211);
  endtask

  task automatic t_soft_rst;
    int n;
    io_wr(10'h314, 16'hFFFF);
    repeat (3) begin
      @(negedge clk); check("R5 write no pulse", soft_rst, 0);
    end
    io_rd(10'h312); check("R5 ptr kept", r_d, 16'h0007);
    io_wr(10'h312, 16'h0003);
    byte_mode = 1;
    io_rd(10'h315);
    n = 0;
    while (soft_rst && n < 20) begin n++; @(negedge clk); end
    check("R5 pulse length", 32'(n), 4);
    byte_mode = 0;
    @(negedge clk);
    io_rd(10'h312); check("R6 ptr cleared", r_d, 0);
    io_wr(10'h312, 16'h0003);
    io_rd(10'h310); check("R6 bank A cleared", r_d, 0);
    io_rd(10'h316); check("R6 bank B cleared", r_d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_station();
    t_banks();
    t_cs16();
    t_byte_write();
    t_coherent();
    t_soft_rst();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule